// File: doc/BRIEF.md
# PWM output protection controller

This block sits between the CPU bus and a six-phase complementary PWM output stage. It keeps the stage safe from software that has run away and from faults on the board. A single access-enable bit guards a set of protected timer registers: the mode, control, compare and counter registers. While the bit is clear, bus writes to that set are dropped and reads return zero. A small group of buffer registers stays open at all times, so waveform updates can go on while the configuration is frozen.

An output shutdown path removes drive from all six PWM pins when any of four external fault inputs is raised. The fault inputs are synchronised and held in sticky flags. Drive is also removed when a monitor clocked by an independent reference clock sees that the main clock has stopped. This shutdown does not wait for the main clock. Drive comes back only after software clears each cause, because the pin state after a clock restart is not trustworthy. Out of reset the pins are undriven until software releases a startup hold.

Top module: `pwm_guard`

## Requirements
- R1: After reset the access-enable bit (address 0x30, bit 0) reads 1, the status register (0x32) reads 0x20 with only the startup hold bit 5 set, protected registers read 0 and `pwm_oe` is all zeros.
- R2: With access enabled, a write to a protected address 0x00 to 0x14 is stored and read back. Address 0x00 keeps only bits 5:0, which are the per-pin software enables. Addresses outside the map read 0.
- R3: With access disabled, writes to protected addresses leave their contents unchanged. The old value is seen after access is enabled again.
- R4: With access disabled, every read of a protected address returns 0.
- R5: The buffer registers at 0x20 to 0x23 are written and read back whatever the access-enable bit holds.
- R6: The access-enable bit is itself always writable. Writing 0 closes the protected set and writing 1 opens it.
- R7: A high level on `fault_in[k]` sets status bit k and forces `pwm_oe` to zero on the third rising `clk` edge after it is applied, not earlier.
- R8: Writing 1 to status bit k clears that fault flag only when the synchronised input k is low. While the input is still high the flag stays set.
- R9: Each bit of `pwm_oe` equals its software enable ANDed with the absence of every shutdown cause. `pwm_out` is `pwm_in` gated by `pwm_oe`.
- R10: If `clk` stops, `pwm_oe` drops to zero without any `clk` edge once the reference-clock counter reaches the timeout held at 0x33 (reset value 16, nonzero). It does not drop before then.
- R11: After a halt, `pwm_oe` stays zero and status bit 4 reads 1 when `clk` returns. Both stay that way until software writes 1 to status bit 4.
- R12: The startup hold (status bit 5) keeps `pwm_oe` at zero until software writes 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, the one being monitored |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_clk | input | 1 | Independent reference clock for the halt monitor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| fault_in | input | 4 | External fault inputs, active high |
| pwm_in | input | 6 | PWM phases from the waveform generator |
| pwm_out | output | 6 | PWM phase data gated by the output enables |
| pwm_oe | output | 6 | Per-pin pad output enables, 0 means high impedance |

## Verification
The bench builds the block with its default parameters: 21 protected registers, 4 buffers, a 16-cycle halt timeout and a heartbeat that toggles every 4 main-clock cycles. The reference clock runs at a 30 ns period. With these values one heartbeat gap lasts about three reference cycles, well under the timeout, while a real stop trips the monitor in about 600 ns. So the bench can check the halt both before and after the timeout inside a short stop of the main clock. It then raises the timeout to 40 and shows that the same stop no longer trips at the earlier time. Random lock toggles mixed with writes and reads cover all 21 protected addresses, including the last one at 0x14 and the first unmapped address next to it.

// File: rtl/pwm_guard.sv
`timescale 1ns/1ps
module pwm_guard #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int NPROT = 21,
  parameter int NBUF = 4,
  parameter int NPIN = 6,
  parameter int NFLT = 4,
  parameter int TMO_W = 8,
  parameter int TMO_INIT = 16,
  parameter int HB_DIV = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_clk,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NFLT-1:0] fault_in,
  input  logic [NPIN-1:0] pwm_in,
  output logic [NPIN-1:0] pwm_out,
  output logic [NPIN-1:0] pwm_oe
);
  localparam int PIW = $clog2(NPROT);
  localparam int BIW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam logic [AW-1:0] BUF_BASE = AW'(32);
  localparam logic [AW-1:0] CTL_A = AW'(48);
  localparam logic [AW-1:0] STAT_A = AW'(50);
  localparam logic [AW-1:0] TMO_A = AW'(51);
  localparam logic [DW-1:0] SW_MASK = DW'((64'd1 << NPIN) - 64'd1);

  logic [NPROT-1:0][DW-1:0] prot_q;
  logic [NBUF-1:0][DW-1:0]  buf_q;
  logic                     acc_en_q, hold_q, clr_tgl_q;
  logic [NFLT-1:0]          f1_q, f2_q, flt_q, flt_clr;
  logic [TMO_W-1:0]         tmo_q;
  logic [HB_DIV:0]          hb_cnt_q;
  logic [1:0]               halt_s_q;

  logic [1:0]               rrst_q;
  logic [2:0]               hb_s_q, clr_s_q;
  logic [TMO_W-1:0]         cnt_q;
  logic                     halt_r;

  wire [PIW-1:0] pidx = bus_addr[PIW-1:0];
  wire [BIW-1:0] bidx = bus_addr[BIW-1:0];
  wire hit_prot = bus_addr < AW'(NPROT);
  wire hit_buf  = (bus_addr >= BUF_BASE) && (bus_addr < BUF_BASE + AW'(NBUF));
  wire wr_stat  = bus_wr && (bus_addr == STAT_A);
  wire [NPIN-1:0] sw_en = prot_q[0][NPIN-1:0];
  wire shut = (|flt_q) | halt_r | hold_q;

  assign flt_clr = wr_stat ? (bus_wdata[NFLT-1:0] & ~f2_q) : '0;
  assign pwm_oe  = sw_en & ~{NPIN{shut}};
  assign pwm_out = pwm_in & pwm_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q    <= '0;
      buf_q     <= '0;
      acc_en_q  <= 1'b1;
      hold_q    <= 1'b1;
      clr_tgl_q <= 1'b0;
      f1_q      <= '0;
      f2_q      <= '0;
      flt_q     <= '0;
      tmo_q     <= TMO_W'(TMO_INIT);
      hb_cnt_q  <= '0;
      halt_s_q  <= '0;
    end else begin
      f1_q     <= fault_in;
      f2_q     <= f1_q;
      flt_q    <= (flt_q & ~flt_clr) | f2_q;
      hb_cnt_q <= hb_cnt_q + 1'b1;
      halt_s_q <= {halt_s_q[0], halt_r};
      if (bus_wr && hit_prot && acc_en_q)
        prot_q[pidx] <= (pidx == '0) ? (bus_wdata & SW_MASK) : bus_wdata;
      if (bus_wr && hit_buf)
        buf_q[bidx] <= bus_wdata;
      if (bus_wr && bus_addr == CTL_A)
        acc_en_q <= bus_wdata[0];
      if (wr_stat && bus_wdata[NFLT+1])
        hold_q <= 1'b0;
      if (wr_stat && bus_wdata[NFLT])
        clr_tgl_q <= ~clr_tgl_q;
      if (bus_wr && bus_addr == TMO_A)
        tmo_q <= bus_wdata[TMO_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_prot) begin
      if (acc_en_q) bus_rdata = prot_q[pidx];
    end else if (hit_buf)
      bus_rdata = buf_q[bidx];
    else if (bus_addr == CTL_A)
      bus_rdata = DW'(acc_en_q);
    else if (bus_addr == STAT_A)
      bus_rdata = DW'({hold_q, halt_s_q[1], flt_q});
    else if (bus_addr == TMO_A)
      bus_rdata = DW'(tmo_q);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rrst_q <= '0;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end

  wire hb_edge  = hb_s_q[2] ^ hb_s_q[1];
  wire clr_edge = clr_s_q[2] ^ clr_s_q[1];

  always_ff @(posedge ref_clk or negedge rrst_q[1]) begin
    if (!rrst_q[1]) begin
      hb_s_q  <= '0;
      clr_s_q <= '0;
      cnt_q   <= '0;
      halt_r  <= 1'b0;
    end else begin
      hb_s_q  <= {hb_s_q[1:0], hb_cnt_q[HB_DIV]};
      clr_s_q <= {clr_s_q[1:0], clr_tgl_q};
      if (hb_edge)            cnt_q <= '0;
      else if (cnt_q < tmo_q) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= tmo_q)     halt_r <= 1'b1;
      else if (clr_edge)      halt_r <= 1'b0;
    end
  end
endmodule

module pwm_guard_chk #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int NPROT = 21,
  parameter int NPIN = 6,
  parameter int NFLT = 4
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [AW-1:0]            bus_addr,
  input logic [DW-1:0]            bus_rdata,
  input logic [NFLT-1:0]          fault_in,
  input logic [NPIN-1:0]          pwm_oe,
  input logic                     acc_en_q,
  input logic                     hold_q,
  input logic [NPROT-1:0][DW-1:0] prot_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R3
  locked_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !acc_en_q && bus_addr < AW'(NPROT)) |=> $stable(prot_q));
  // R4
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en_q && bus_addr < AW'(NPROT)) |-> bus_rdata == '0);
  // R7
  fault_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && |$past(fault_in, 3)) |-> pwm_oe == '0);
  // R9
  oe_within_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe & ~prot_q[0][NPIN-1:0]) == '0);
  // R12
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> pwm_oe == '0);
endmodule

bind pwm_guard pwm_guard_chk #(.DW(DW), .AW(AW), .NPROT(NPROT), .NPIN(NPIN), .NFLT(NFLT)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .fault_in(fault_in), .pwm_oe(pwm_oe), .acc_en_q(acc_en_q), .hold_q(hold_q), .prot_q(prot_q));

// File: tb/pwm_guard_tb_top.sv
`timescale 1ns/1ps
module pwm_guard_tb_top;
  logic clk_raw = 1'b0, clk_run = 1'b1, ref_clk = 1'b0, rst_n = 1'b0;
  logic clk;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [3:0] fault_in = '0;
  logic [5:0] pwm_in = 6'h3F, pwm_out, pwm_oe;

  always #10 clk_raw = ~clk_raw;
  always #15 ref_clk = ~ref_clk;
  assign clk = clk_raw & clk_run;

  pwm_guard dut_i (.clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in), .pwm_in(pwm_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mp [21];
  logic [15:0] mb [4];
  bit me = 1'b1;
  logic [15:0] rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [5:0] exp_oe(input logic [5:0] sw, input logic [5:0] stat);
    return (stat == 6'd0) ? sw : 6'd0;
  endfunction

  task automatic fin();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    fin();
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (mp[i]) mp[i] = '0;
    foreach (mb[i]) mb[i] = '0;
    repeat (5) @(negedge clk_raw);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h30, rv); chk("R1 ctl", rv, 1);
    rd(6'h32, rv); chk("R1 stat", rv, 16'h20);
    rd(6'h05, rv); chk("R1 prot", rv, 0);
    chk("R1 oe", pwm_oe, 0);

    // R12 startup hold
    wr(6'h00, 16'h0029); mp[0] = 16'h0029;
    #1 chk("R12 hold keeps oe low", pwm_oe, 0);
    wr(6'h32, 16'h0020);
    rd(6'h32, rv); chk("R12 stat", rv, 0);
    // R9 per-pin enable
    chk("R9 oe", pwm_oe, 6'h29);
    pwm_in = 6'h0F; #1 chk("R9 out", pwm_out, 6'h09);
    pwm_in = 6'h3F;

    // R2 / R3 / R4 / R5 / R6 directed
    wr(6'h00, 16'hFFFF); rd(6'h00, rv); chk("R2 mask", rv, 16'h003F);
    wr(6'h00, 16'h0029);
    wr(6'h14, 16'hBEEF); rd(6'h14, rv); chk("R2 last prot", rv, 16'hBEEF); mp[20] = 16'hBEEF;
    rd(6'h15, rv); chk("R2 unmapped", rv, 0);
    wr(6'h30, 16'h0000); rd(6'h30, rv); chk("R6 closed", rv, 0);
    rd(6'h14, rv); chk("R4 locked read", rv, 0);
    wr(6'h14, 16'h1234); wr(6'h00, 16'h003F);
    #1 chk("R3 oe unchanged", pwm_oe, 6'h29);
    wr(6'h20, 16'hA5A5); rd(6'h20, rv); chk("R5 buf locked", rv, 16'hA5A5); mb[0] = 16'hA5A5;
    wr(6'h30, 16'h0001); rd(6'h30, rv); chk("R6 open", rv, 1);
    rd(6'h14, rv); chk("R3 kept", rv, 16'hBEEF);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, idx;
      logic [15:0] d;
      op = $urandom % 5; d = 16'($urandom);
      case (op)
        0: begin me = d[0]; wr(6'h30, {15'd0, d[0]}); end
        1: begin
          idx = $urandom % 21;
          wr(6'(idx), d);
          if (me) mp[idx] = (idx == 0) ? (d & 16'h003F) : d;
        end
        2: begin idx = $urandom % 4; wr(6'h20 + 6'(idx), d); mb[idx] = d; end
        3: begin
          idx = $urandom % 21; rd(6'(idx), rv);
          chk(me ? "R2 rand prot" : "R4 rand locked", rv, me ? mp[idx] : 16'd0);
        end
        default: begin
          idx = $urandom % 4; rd(6'h20 + 6'(idx), rv); chk("R5 rand buf", rv, mb[idx]);
          chk("R9 rand oe", pwm_oe, exp_oe(mp[0][5:0], 6'd0));
        end
      endcase
    end
    if (!me) begin wr(6'h30, 16'h0001); me = 1'b1; end
    rd(6'h03, rv); chk("R3 after rand", rv, mp[3]);
    wr(6'h00, 16'h003F); mp[0] = 16'h003F;

    // R7 / R8 faults
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); fault_in[k] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); chk("R7 not yet", pwm_oe, 6'h3F);
      @(negedge clk); chk("R7 shut", pwm_oe, 0);
      rd(6'h32, rv); chk("R7 stat", rv, 16'(1 << k));
      wr(6'h32, 16'(1 << k));
      rd(6'h32, rv); chk("R8 held while active", rv, 16'(1 << k));
      fault_in[k] = 1'b0;
      repeat (3) @(negedge clk);
      wr(6'h32, 16'(1 << k));
      rd(6'h32, rv); chk("R8 cleared", rv, 0);
      chk("R9 restored", pwm_oe, 6'h3F);
    end

    // R10 / R11 halt with default timeout
    @(negedge clk_raw); clk_run = 1'b0;
    #100 chk("R10 before timeout", pwm_oe, 6'h3F);
    #1900 chk("R10 halted", pwm_oe, 0);
    @(negedge clk_raw); clk_run = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11 stays off", pwm_oe, 0);
    rd(6'h32, rv); chk("R11 stat", rv, 16'h10);
    wr(6'h32, 16'h0010);
    repeat (20) @(negedge clk);
    rd(6'h32, rv); chk("R11 cleared", rv, 0);
    chk("R11 oe back", pwm_oe, 6'h3F);

    // R10 programmable timeout
    wr(6'h33, 16'd40); rd(6'h33, rv); chk("R10 tmo", rv, 40);
    repeat (4) @(negedge clk);
    @(negedge clk_raw); clk_run = 1'b0;
    #800 chk("R10 longer timeout", pwm_oe, 6'h3F);
    #1700 chk("R10 halted late", pwm_oe, 0);
    @(negedge clk_raw); clk_run = 1'b1;
    repeat (10) @(negedge clk);
    wr(6'h32, 16'h0010);
    repeat (20) @(negedge clk);
    chk("R11 oe back again", pwm_oe, 6'h3F);

    fin();
  end
endmodule